// File: doc/BRIEF.md
# Radix Page Table Walker

This block resolves one effective address by walking a multi-level radix tree held in memory. A request supplies the effective address, the base of the root directory, the number of index bits used at the root and the width of the address space in bits. The walker then reads one 64-bit entry per level through a simple memory request/response port. At each directory entry it takes the index width and base of the next table and moves down, until it reaches a leaf, an invalid entry or a tree shape that is not allowed.

Before every read, the walker checks the shape of the level it is about to index against a fixed list of allowed shapes. If the shape is not allowed, the walk stops with a bad-configuration code and nothing more is read from memory. A table base whose low bits are not aligned to the table's own size does not cause a fault: those low bits are cleared and the walk goes on. At the end of a walk the block pulses `done` for one cycle. With that pulse it presents the last entry it read, the address of that entry, the resolved page size and a two-bit fault code.

Top module: `radix_walker`

## Requirements
- R1: After reset the walker is idle: `reqReady` is 1, `done` is 0 and `memReqValid` is 0.
- R2: A request is taken only in a cycle where `reqValid` and `reqReady` are both 1. `reqReady` is 0 from the cycle after acceptance until the walk has ended, including the cycle in which `done` is high, so a request held during that time starts no second walk.
- R3: At each level the index is the effective address shifted right by (remaining size − index width), keeping the low index-width bits. The entry is read at the table base plus 8 times the index.
- R4: Before the entry address is formed, the low (index width + 3) bits of the table base are cleared. This applies at the root and at every lower level, raises no fault and does not stop the walk.
- R5: Level 0 may be read only when the remaining size is 52 and the index width is 13. Otherwise the walk ends with fault code 1 (bad configuration) and no memory read takes place.
- R6: Levels 1 and 2 allow only an index width of 9. Level 3 allows 9 or 5. Any level of 4 or higher fails. A failed check ends the walk with fault code 1 and no read for that level.
- R7: In an entry, bit 63 is the valid bit and bit 62 is the leaf bit. Bits 4:0 give the next index width and bits 59:8 give the next table base (the base address is this field shifted left by 8). A valid entry that is not a leaf leads to a descent: the remaining size drops by the current index width, and then the entry's width and base become the current ones.
- R8: An entry whose bit 63 is 0 ends the walk with fault code 2 (not found). That entry and its address are reported.
- R9: A valid leaf entry ends the walk with fault code 0. The page size reported is the remaining size minus the current index width, and the leaf entry and its address are reported.
- R10: A memory request stays up with an unchanged, 8-byte-aligned address until `memReqReady` is seen. At most one read is in flight at any time.
- R11: `done` is high for exactly one cycle per accepted request, and the result outputs are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request present |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqEaddr | input | 64 | Effective address to translate |
| reqBase | input | 64 | Root table base |
| reqNls | input | 5 | Root index width |
| reqSize | input | 6 | Address-space size in bits |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory takes the request |
| memReqAddr | output | 64 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data present |
| memRspData | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle end-of-walk pulse |
| resEntry | output | 64 | Last entry read (zero if none was read) |
| resAddr | output | 64 | Address of the last entry read |
| resPageSize | output | 6 | Page size in bits on success |
| resFault | output | 2 | 0 success, 1 bad configuration, 2 not found |

## Verification
Base alignment and the geometry check both happen in the same check cycle. A misaligned root base combined with a misaligned lower-level base is therefore driven on a legal tree: the result must match the aligned walk exactly and no fault may appear. Illegal shapes at level 0, level 1 and level 4 are judged by the fault code and by counting memory reads. The end of a walk and a newly arriving request can also meet in the cycle where `done` is high. A request is held on the inputs for the whole walk, including that cycle, and the bench then confirms that the read count and the results belong to one walk only.

// File: rtl/walk_pkg.sv
package walk_pkg;

  // Entry field positions
  localparam int VALID_BIT = 63;
  localparam int LEAF_BIT  = 62;
  localparam int NLB_HI    = 59;
  localparam int NLB_LO    = 8;
  localparam int NLS_HI    = 4;

  // Allowed tree shapes
  localparam int ROOT_SIZE  = 52;
  localparam int ROOT_NLS   = 13;
  localparam int MID_NLS    = 9;
  localparam int SHORT_NLS  = 5;
  localparam int LAST_LEVEL = 3;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_BADCFG   = 2'd1,
    FLT_NOTFOUND = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_WAIT,
    ST_DONE
  } walkState_e;

  typedef struct packed {
    logic load;
    logic check;
    logic capture;
  } walkStrobe_t;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        levelOk,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        rspValidBit,
  input  logic        rspLeafBit,
  output walkStrobe_t strobe,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        done
);

  walkState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    done        = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.load = 1'b1;
          stateD      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        strobe.check = 1'b1;
        stateD       = levelOk ? ST_FETCH : ST_DONE;
      end
      ST_FETCH: begin
        memReqValid = 1'b1;
        if (memReqReady) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          strobe.capture = 1'b1;
          stateD = (!rspValidBit || rspLeafBit) ? ST_DONE : ST_CHECK;
        end
      end
      ST_DONE: begin
        done   = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 6,
  parameter int NLS_W  = 5,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [DATA_W-1:0] reqEaddr,
  input  logic [DATA_W-1:0] reqBase,
  input  logic [NLS_W-1:0]  reqNls,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [DATA_W-1:0] memRspData,
  output logic              levelOk,
  output logic              rspValidBit,
  output logic              rspLeafBit,
  output logic [DATA_W-1:0] resEntry,
  output logic [DATA_W-1:0] resAddr,
  output logic [SIZE_W-1:0] resPageSize,
  output logic [1:0]        resFault
);

  localparam int LVL_N   = 2 ** LVL_W;
  localparam int TOP_PAD = DATA_W - NLB_HI - 1;

  logic [DATA_W-1:0] eaddrQ, baseQ, addrQ, entryQ;
  logic [NLS_W-1:0]  nlsQ;
  logic [SIZE_W-1:0] sizeQ, pageQ;
  logic [LVL_W-1:0]  levelQ;
  fault_e            faultQ;

  logic [SIZE_W-1:0] shiftAmt;
  logic [NLS_W:0]    alignBits;
  logic [DATA_W-1:0] idxMask, alignMask, entryIdx, baseAligned, nextAddr;
  logic [LVL_N-1:0]  legalVec;

  // Per-level geometry whitelist
  for (genvar lv = 0; lv < LVL_N; lv++) begin : g_lvl
    if (lv == 0) begin : g_root
      assign legalVec[lv] = (sizeQ == SIZE_W'(ROOT_SIZE)) && (nlsQ == NLS_W'(ROOT_NLS));
    end else if (lv < LAST_LEVEL) begin : g_mid
      assign legalVec[lv] = (nlsQ == NLS_W'(MID_NLS));
    end else if (lv == LAST_LEVEL) begin : g_last
      assign legalVec[lv] = (nlsQ == NLS_W'(MID_NLS)) || (nlsQ == NLS_W'(SHORT_NLS));
    end else begin : g_over
      assign legalVec[lv] = 1'b0;
    end
  end

  assign levelOk = legalVec[levelQ];

  // Index and entry address
  always_comb begin
    shiftAmt    = sizeQ - SIZE_W'(nlsQ);
    idxMask     = (DATA_W'(1) << nlsQ) - DATA_W'(1);
    alignBits   = {1'b0, nlsQ} + (NLS_W + 1)'(3);
    alignMask   = (DATA_W'(1) << alignBits) - DATA_W'(1);
    entryIdx    = (eaddrQ >> shiftAmt) & idxMask;
    baseAligned = baseQ & ~alignMask;
    nextAddr    = baseAligned + (entryIdx << 3);
  end

  assign rspValidBit = memRspData[VALID_BIT];
  assign rspLeafBit  = memRspData[LEAF_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaddrQ <= '0;
      baseQ  <= '0;
      addrQ  <= '0;
      entryQ <= '0;
      nlsQ   <= '0;
      sizeQ  <= '0;
      pageQ  <= '0;
      levelQ <= '0;
      faultQ <= FLT_NONE;
    end else if (strobe.load) begin
      eaddrQ <= reqEaddr;
      baseQ  <= reqBase;
      nlsQ   <= reqNls;
      sizeQ  <= reqSize;
      addrQ  <= '0;
      entryQ <= '0;
      pageQ  <= '0;
      levelQ <= '0;
      faultQ <= FLT_NONE;
    end else if (strobe.check) begin
      levelQ <= levelQ + LVL_W'(1);
      if (levelOk) addrQ  <= nextAddr;
      else         faultQ <= FLT_BADCFG;
    end else if (strobe.capture) begin
      entryQ <= memRspData;
      if (!memRspData[VALID_BIT]) begin
        faultQ <= FLT_NOTFOUND;
      end else if (memRspData[LEAF_BIT]) begin
        pageQ <= sizeQ - SIZE_W'(nlsQ);
      end else begin
        sizeQ <= sizeQ - SIZE_W'(nlsQ);
        nlsQ  <= memRspData[NLS_HI:0];
        baseQ <= {{TOP_PAD{1'b0}}, memRspData[NLB_HI:NLB_LO], {NLB_LO{1'b0}}};
      end
    end
  end

  assign resEntry    = entryQ;
  assign resAddr     = addrQ;
  assign resPageSize = pageQ;
  assign resFault    = faultQ;

endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import walk_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 6,
  parameter int NLS_W  = 5,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [DATA_W-1:0] reqEaddr,
  input  logic [DATA_W-1:0] reqBase,
  input  logic [NLS_W-1:0]  reqNls,
  input  logic [SIZE_W-1:0] reqSize,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [DATA_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              done,
  output logic [DATA_W-1:0] resEntry,
  output logic [DATA_W-1:0] resAddr,
  output logic [SIZE_W-1:0] resPageSize,
  output logic [1:0]        resFault
);

  walkStrobe_t strobe;
  logic        levelOk, rspValidBit, rspLeafBit;

  walk_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .levelOk     (levelOk),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspValidBit (rspValidBit),
    .rspLeafBit  (rspLeafBit),
    .strobe      (strobe),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .done        (done)
  );

  walk_dpath #(
    .DATA_W (DATA_W),
    .SIZE_W (SIZE_W),
    .NLS_W  (NLS_W),
    .LVL_W  (LVL_W)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqEaddr    (reqEaddr),
    .reqBase     (reqBase),
    .reqNls      (reqNls),
    .reqSize     (reqSize),
    .memRspData  (memRspData),
    .levelOk     (levelOk),
    .rspValidBit (rspValidBit),
    .rspLeafBit  (rspLeafBit),
    .resEntry    (resEntry),
    .resAddr     (resAddr),
    .resPageSize (resPageSize),
    .resFault    (resFault)
  );

  assign memReqAddr = resAddr;

endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [DATA_W-1:0] memReqAddr,
  input logic              done,
  input logic [1:0]        resFault,
  input logic [1:0]        entryFlags
);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R10
  mem_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[2:0] == 3'd0);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R2
  no_accept_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !reqReady && !memReqValid);

  // R9
  leaf_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && resFault == 2'd0 |-> entryFlags == 2'b11);

  // R8
  notfound_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && resFault == 2'd2 |-> !entryFlags[1]);

endmodule

bind radix_walker radix_walker_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .done        (done),
  .resFault    (resFault),
  .entryFlags  (resEntry[63:62])
);

// File: tb/radix_walker_tb_top.sv
module radix_walker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqEaddr = '0;
  logic [63:0] reqBase = '0;
  logic [4:0]  reqNls = '0;
  logic [5:0]  reqSize = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [63:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        done;
  logic [63:0] resEntry, resAddr;
  logic [5:0]  resPageSize;
  logic [1:0]  resFault;

  always #(CLK_PERIOD / 2) clk = ~clk;

  radix_walker dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqEaddr(reqEaddr), .reqBase(reqBase), .reqNls(reqNls), .reqSize(reqSize),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .done(done), .resEntry(resEntry), .resAddr(resAddr),
    .resPageSize(resPageSize), .resFault(resFault)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int totalReads = 0;
  bit finished = 1'b0;

  logic [63:0] mem [longint unsigned];

  typedef struct {
    logic [1:0]  fault;
    logic [5:0]  page;
    logic [63:0] addr;
    logic [63:0] entry;
    int          reads;
    int          readsAt;
    bit          full;
    string       tag;
  } item_t;

  item_t sbQ [$];

  function automatic logic [63:0] rdMem(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'd0;
  endfunction

  // Memory model: ready pattern stalls some cycles, data one cycle later
  always @(posedge clk) begin
    cyc <= cyc + 1;
    memReqReady <= (cyc % 3) != 2;
    memRspValid <= 1'b0;
    if (rstN && memReqValid && memReqReady) begin
      memRspValid <= 1'b1;
      memRspData  <= rdMem(memReqAddr);
      totalReads  <= totalReads + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares each finished walk with the head of the scoreboard (R11)
  always @(negedge clk) begin
    if (rstN && done && !finished) begin
      if (sbQ.size() == 0) begin
        check(1'b0, "R2/R11", "unexpected done", 64'd1, 64'd0);
      end else begin
        item_t it;
        it = sbQ.pop_front();
        check(resFault == it.fault, it.tag, "fault", 64'(resFault), 64'(it.fault));
        check(totalReads - it.readsAt == it.reads, it.tag, "reads",
              64'(totalReads - it.readsAt), 64'(it.reads));
        if (it.full) begin
          check(resAddr == it.addr, it.tag, "addr", resAddr, it.addr);
          check(resEntry == it.entry, it.tag, "entry", resEntry, it.entry);
          if (it.fault == 2'd0)
            check(resPageSize == it.page, it.tag, "page", 64'(resPageSize), 64'(it.page));
        end
      end
    end
  end

  // Entry builders (R7 format)
  function automatic logic [63:0] mkDir(input logic [63:0] base, input logic [4:0] nls);
    return 64'h8000_0000_0000_0000 | (base & 64'h0FFF_FFFF_FFFF_FF00) | 64'(nls);
  endfunction

  function automatic logic [63:0] mkLeaf(input logic [63:0] rpn);
    return 64'hC000_0000_0000_0000 | (rpn & 64'h0FFF_FFFF_FFFF_FF00);
  endfunction

  // R3 index rule
  function automatic logic [63:0] idxOf(input logic [63:0] ea, input int remain, input int nls);
    return (ea >> (remain - nls)) & ((64'd1 << nls) - 64'd1);
  endfunction

  localparam logic [63:0] ROOT = 64'h0010_0000;
  localparam logic [63:0] B1   = 64'h0020_0000;
  localparam logic [63:0] B2   = 64'h0030_0000;
  localparam logic [63:0] B3   = 64'h0040_0000;
  localparam logic [63:0] LEAF = 64'hC000_0000_5555_5000;

  function automatic logic [63:0] a0(input logic [63:0] ea); return ROOT + idxOf(ea, 52, 13) * 8; endfunction
  function automatic logic [63:0] a1(input logic [63:0] ea); return B1 + idxOf(ea, 39, 9) * 8; endfunction
  function automatic logic [63:0] a2(input logic [63:0] ea); return B2 + idxOf(ea, 30, 9) * 8; endfunction
  function automatic logic [63:0] a3(input logic [63:0] ea); return B3 + idxOf(ea, 21, 9) * 8; endfunction

  task automatic build4(input logic [63:0] ea);
    mem.delete();
    mem[a0(ea)] = mkDir(B1, 9);
    mem[a1(ea)] = mkDir(B2, 9);
    mem[a2(ea)] = mkDir(B3, 9);
    mem[a3(ea)] = LEAF;
  endtask

  task automatic runWalk(input logic [63:0] ea, input logic [63:0] base,
                         input logic [4:0] nls, input logic [5:0] sz,
                         input logic [1:0] eFault, input logic [5:0] ePage,
                         input logic [63:0] eAddr, input logic [63:0] eEntry,
                         input int eReads, input bit full, input bit hold,
                         input string tag);
    item_t it;
    int readsBefore;
    it.fault = eFault; it.page = ePage; it.addr = eAddr; it.entry = eEntry;
    it.reads = eReads; it.readsAt = totalReads; it.full = full; it.tag = tag;
    readsBefore = totalReads;
    sbQ.push_back(it);
    @(negedge clk);
    reqValid = 1'b1; reqEaddr = ea; reqBase = base; reqNls = nls; reqSize = sz;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    if (!hold) begin
      reqValid = 1'b0;
    end else begin
      // Keep a different request up through the whole walk (R2)
      reqEaddr = 64'h0000_0123_4567_8000; reqBase = ROOT; reqNls = 5'd13; reqSize = 6'd52;
      check(reqReady == 1'b0, "R2", "ready while busy", 64'(reqReady), 64'd0);
      while (!done) @(negedge clk);
      check(reqReady == 1'b0, "R2", "ready in done cycle", 64'(reqReady), 64'd0);
      reqValid = 1'b0;
    end
    while (sbQ.size() != 0) @(negedge clk);
    if (hold) begin
      repeat (8) @(negedge clk);
      check(totalReads - readsBefore == eReads, "R2", "reads after held request",
            64'(totalReads - readsBefore), 64'(eReads));
      check(reqReady == 1'b1, "R2", "idle again", 64'(reqReady), 64'd1);
    end
  endtask

  // Watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog expired: actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] e1, e2;
    e1 = 64'h000A_BCDE_F123_4567;
    e2 = 64'h0000_1234_5678_9ABC;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady", 64'(reqReady), 64'd1);
    check(done == 1'b0, "R1", "done", 64'(done), 64'd0);
    check(memReqValid == 1'b0, "R1", "memReqValid", 64'(memReqValid), 64'd0);

    // R3 R7 R9: four-level walk to a 4K page
    build4(e1);
    runWalk(e1, ROOT, 13, 52, 2'd0, 6'd12, a3(e1), LEAF, 4, 1, 0, "R3/R7/R9 4-level e1");

    // R3 second address pattern
    build4(e2);
    runWalk(e2, ROOT, 13, 52, 2'd0, 6'd12, a3(e2), LEAF, 4, 1, 0, "R3/R9 4-level e2");

    // R9 leaf at level 2
    build4(e1);
    mem[a2(e1)] = mkLeaf(64'h0000_0000_7720_0000);
    runWalk(e1, ROOT, 13, 52, 2'd0, 6'd21, a2(e1), mkLeaf(64'h0000_0000_7720_0000),
            3, 1, 0, "R9 leaf level2");

    // R9 leaf at level 0
    build4(e1);
    mem[a0(e1)] = mkLeaf(64'h0000_8000_0000_0000);
    runWalk(e1, ROOT, 13, 52, 2'd0, 6'd39, a0(e1), mkLeaf(64'h0000_8000_0000_0000),
            1, 1, 0, "R9 leaf level0");

    // R6 R7 level 3 with 5 index bits
    build4(e1);
    mem[a2(e1)] = mkDir(B3, 5);
    mem[B3 + idxOf(e1, 21, 5) * 8] = LEAF;
    runWalk(e1, ROOT, 13, 52, 2'd0, 6'd16, B3 + idxOf(e1, 21, 5) * 8, LEAF,
            4, 1, 0, "R6/R7 short last level");

    // R4 misaligned root and level-1 bases are silently corrected
    build4(e1);
    mem[a0(e1)] = mkDir(B1 | 64'hA00, 9);
    runWalk(e1, ROOT | 64'h1238, 13, 52, 2'd0, 6'd12, a3(e1), LEAF, 4, 1, 0, "R4 misaligned bases");

    // R5 wrong root size and wrong root width: no read
    build4(e1);
    runWalk(e1, ROOT, 13, 48, 2'd1, 6'd0, 64'd0, 64'd0, 0, 0, 0, "R5 root size 48");
    runWalk(e1, ROOT, 12, 52, 2'd1, 6'd0, 64'd0, 64'd0, 0, 0, 0, "R5 root width 12");

    // R6 level 1 with width 5 is rejected after one read
    build4(e1);
    mem[a0(e1)] = mkDir(B1, 5);
    runWalk(e1, ROOT, 13, 52, 2'd1, 6'd0, 64'd0, 64'd0, 1, 0, 0, "R6 level1 width5");

    // R6 a fifth level is rejected
    build4(e1);
    mem[a3(e1)] = mkDir(64'h0050_0000, 9);
    runWalk(e1, ROOT, 13, 52, 2'd1, 6'd0, 64'd0, 64'd0, 4, 0, 0, "R6 level4");

    // R8 invalid entry at level 1
    build4(e1);
    mem.delete(a1(e1));
    runWalk(e1, ROOT, 13, 52, 2'd2, 6'd0, a1(e1), 64'd0, 2, 1, 0, "R8 invalid level1");

    // R8 invalid but nonzero entry at level 3
    build4(e1);
    mem[a3(e1)] = 64'h4000_0000_1234_5600;
    runWalk(e1, ROOT, 13, 52, 2'd2, 6'd0, a3(e1), 64'h4000_0000_1234_5600,
            4, 1, 0, "R8 invalid level3");

    // R2 R11 request held through the walk and its done cycle
    build4(e1);
    runWalk(e1, ROOT, 13, 52, 2'd0, 6'd12, a3(e1), LEAF, 4, 1, 1, "R2/R11 held request");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule